// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

The block supervises software through a 24-bit down-counter that steps once every four clocks. Software programs these values over a small single-cycle register bus:

- a reload constant;
- an upper window bound;
- a warning threshold;
- the enable bit and the protect bit.

Software then feeds the timer by writing two key bytes in a row. If the count expires, the block issues a one-cycle reset request. It does the same when a feed arrives while the count is still above the window bound, or when the key sequence is broken. Before expiry, it raises a sticky interrupt as the count passes the warning threshold.

The enable and protect bits are one-way. Once set, only a reset clears them: either the external reset or the block's own watchdog reset. A watchdog reset returns every setting to its reset value. It sets a timeout flag that stays set so that software can find the cause afterwards. The whole block runs on one clock.

Top module: `win_watchdog`

## Requirements
- R1: After rst_ni is released, the registers read as follows:
  - control (address 0) reads 0;
  - reload constant (address 1) reads 0xFFFFFF;
  - count (address 3) reads 0xFFFFFF;
  - warning threshold (address 4) reads 0;
  - window bound (address 5) reads 0xFFFFFF.
  - irq_o and rst_req_o are low.
  - Control bit positions: bit0 enable, bit1 protect, bit2 timeout flag, bit3 warning flag, bit4 running.
- R2: A reload-constant write below 256 is stored as 256. Any other value is stored unchanged.
- R3: Writing 1 to control bit0 or bit1 sets that bit. Writing 0 never clears it.
- R4: While the enable bit is 0, feeds and bad key writes have no effect.
  - After enable, the first valid feed loads the reload constant and starts the count.
  - The count then drops by one every 4 clocks and is readable at address 3.
- R5: With no further feed, rst_req_o is high for exactly one cycle, 4×C clocks after the clock that accepted the final feed write, where C is the reload constant.
- R6: A feed is the write of 0xAA, then the next access writing 0x55, both to address 2. An accepted feed while running reloads the count from the reload constant.
- R7: While running, a feed that completes with the count above the window bound causes a reset request on the next cycle. A feed at or below the bound is accepted.
- R8: While enabled, a broken key sequence causes a reset request on the next cycle. The sequence is broken by:
  - a first key other than 0xAA;
  - a second key other than 0x55;
  - any other register access between the two keys.
- R9: The warning flag (control bit3, also driven on irq_o) is set one clock after the running count equals the warning threshold. It stays set until 1 is written to bit3.
- R10: With protect set, reload-constant writes are ignored while the count is above the warning threshold. They are accepted once the count is at or below it.
- R11: A watchdog reset request returns every register, the enable, protect, running and warning bits to their reset values. It sets the timeout flag (bit2), which stays set until 1 is written to bit2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Watchdog clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register address |
| wdata_i | input | 24 | Write data |
| rdata_o | output | 24 | Read data of the addressed register (combinational) |
| irq_o | output | 1 | Warning interrupt (sticky flag) |
| rst_req_o | output | 1 | One-cycle watchdog reset request |

## Verification
The hardest situations to reach depend on the exact count value at the moment of a bus access:

- a feed that lands just inside the window;
- a protected reload write made exactly when the count meets the warning threshold;
- the one clock where the warning flag first appears.

The stimulus reaches them by timing accesses from the clock that accepted a feed. The count after n clocks is C minus floor(n/4), so the bench can place a write on the cycle where the count has just reached the boundary value.

Reset requests are matched against a queue of predicted cycle numbers. This catches both late or early expiry and any unexpected request.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [2:0] {
    REG_CTRL = 3'd0,
    REG_TC   = 3'd1,
    REG_FEED = 3'd2,
    REG_CNT  = 3'd3,
    REG_WARN = 3'd4,
    REG_WIN  = 3'd5
  } reg_addr_e;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_PROT = 1;
  localparam int CTRL_TOUT = 2;
  localparam int CTRL_WARN = 3;
  localparam int CTRL_RUN  = 4;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick_o = run_i && (pre_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pre_q <= '0;
    else if (clr_i)       pre_q <= '0;
    else if (run_i)       pre_q <= (pre_q == LAST) ? '0 : pre_q + PW'(1);
  end

  generate
    if (DIV > 1) begin : g_chk
      assert_tick_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/wdt_down_cnt.sv
module wdt_down_cnt #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_o    = cnt_q;
  assign expire_o = tick_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '1;
    else if (clr_i)                    cnt_q <= '1;
    else if (load_i)                   cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && !clr_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  assert_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/wdt_feed_seq.sv
module wdt_feed_seq (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       feed_wr_i,
  input  logic       other_acc_i,
  input  logic [7:0] key_i,
  output logic       ok_o,
  output logic       bad_o
);
  import wdt_pkg::*;

  typedef enum logic {FS_IDLE, FS_ARMED} feed_st_e;
  feed_st_e st_q, st_d;

  always_comb begin
    st_d  = st_q;
    ok_o  = 1'b0;
    bad_o = 1'b0;
    unique case (st_q)
      FS_IDLE: if (feed_wr_i) begin
        if (key_i == KEY_FIRST) st_d = FS_ARMED;
        else                    bad_o = 1'b1;
      end
      FS_ARMED: begin
        if (feed_wr_i) begin
          st_d = FS_IDLE;
          if (key_i == KEY_SECOND) ok_o = 1'b1;
          else                     bad_o = 1'b1;
        end else if (other_acc_i) begin
          st_d  = FS_IDLE;
          bad_o = 1'b1;
        end
      end
      default: st_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= FS_IDLE;
    else if (clr_i) st_q <= FS_IDLE;
    else            st_q <= st_d;
  end

  assert_ok_bad_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ok_o, bad_o}));
  assert_ok_needs_arm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> (st_q == FS_ARMED));
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog #(
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned PRE_DIV = 4,
  parameter int unsigned MIN_TC  = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_o,
  output logic             rst_req_o
);
  import wdt_pkg::*;

  localparam logic [CNT_W-1:0] TC_FLOOR = CNT_W'(MIN_TC);

  logic en_q, prot_q, run_q, tout_q, warn_q, rst_req_q;
  logic [CNT_W-1:0] tc_q, warn_cmp_q, win_q, cnt, tc_next, ctrl_rd;
  logic wr, wr_ctrl, wr_tc, wr_feed, wr_warn, wr_win, other_acc;
  logic feed_ok, feed_bad, tick, expire;
  logic seq_trip, win_trip, to_trip, trip, feed_load, tc_wr_ok;

  assign wr        = req_i && we_i;
  assign wr_ctrl   = wr && (addr_i == REG_CTRL);
  assign wr_tc     = wr && (addr_i == REG_TC);
  assign wr_feed   = wr && (addr_i == REG_FEED);
  assign wr_warn   = wr && (addr_i == REG_WARN);
  assign wr_win    = wr && (addr_i == REG_WIN);
  assign other_acc = req_i && !wr_feed;

  wdt_feed_seq u_feed (
    .clk_i, .rst_ni, .clr_i(trip), .feed_wr_i(wr_feed), .other_acc_i(other_acc),
    .key_i(wdata_i[7:0]), .ok_o(feed_ok), .bad_o(feed_bad)
  );

  wdt_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk_i, .rst_ni, .clr_i(feed_load | trip), .run_i(run_q), .tick_o(tick)
  );

  wdt_down_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .clr_i(trip), .load_i(feed_load), .load_val_i(tc_q),
    .tick_i(tick), .cnt_o(cnt), .expire_o(expire)
  );

  assign seq_trip  = en_q && feed_bad;
  assign win_trip  = en_q && run_q && feed_ok && (cnt > win_q);
  assign to_trip   = run_q && expire;
  assign trip      = seq_trip || win_trip || to_trip;
  assign feed_load = en_q && feed_ok && !trip;
  assign tc_wr_ok  = wr_tc && (!prot_q || cnt <= warn_cmp_q);
  assign tc_next   = (wdata_i < TC_FLOOR) ? TC_FLOOR : wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; prot_q <= 1'b0; run_q <= 1'b0; tout_q <= 1'b0; warn_q <= 1'b0;
      rst_req_q <= 1'b0;
      tc_q <= '1; warn_cmp_q <= '0; win_q <= '1;
    end else begin
      rst_req_q <= trip;
      if (trip) begin
        // watchdog reset: everything back to defaults except the cause flag
        en_q <= 1'b0; prot_q <= 1'b0; run_q <= 1'b0; warn_q <= 1'b0; tout_q <= 1'b1;
        tc_q <= '1; warn_cmp_q <= '0; win_q <= '1;
      end else begin
        if (wr_ctrl && wdata_i[CTRL_EN])   en_q   <= 1'b1;
        if (wr_ctrl && wdata_i[CTRL_PROT]) prot_q <= 1'b1;
        if (wr_ctrl && wdata_i[CTRL_TOUT]) tout_q <= 1'b0;
        if (run_q && cnt == warn_cmp_q)    warn_q <= 1'b1;
        else if (wr_ctrl && wdata_i[CTRL_WARN]) warn_q <= 1'b0;
        if (tc_wr_ok) tc_q       <= tc_next;
        if (wr_warn)  warn_cmp_q <= wdata_i;
        if (wr_win)   win_q      <= wdata_i;
        if (feed_load) run_q     <= 1'b1;
      end
    end
  end

  always_comb begin
    ctrl_rd            = '0;
    ctrl_rd[CTRL_EN]   = en_q;
    ctrl_rd[CTRL_PROT] = prot_q;
    ctrl_rd[CTRL_TOUT] = tout_q;
    ctrl_rd[CTRL_WARN] = warn_q;
    ctrl_rd[CTRL_RUN]  = run_q;
  end

  always_comb begin
    case (addr_i)
      REG_CTRL: rdata_o = ctrl_rd;
      REG_TC:   rdata_o = tc_q;
      REG_CNT:  rdata_o = cnt;
      REG_WARN: rdata_o = warn_cmp_q;
      REG_WIN:  rdata_o = win_q;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o     = warn_q;
  assign rst_req_o = rst_req_q;

  assert_tc_floor_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_q >= TC_FLOOR);
  assert_en_lock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !trip) |=> en_q);
  assert_prot_lock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_q && !trip) |=> prot_q);
  assert_req_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_q |=> !rst_req_q);
  assert_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && run_q && feed_ok && cnt > win_q) |=> rst_req_q);
  assert_seq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && feed_bad) |=> rst_req_q);
  assert_protect_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_q && wr_tc && cnt > warn_cmp_q && !trip) |=> $stable(tc_q));
  assert_wd_reset_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_q |-> (!en_q && !run_q && tout_q && !warn_q));
endmodule

// File: tb/win_watchdog_test.sv
module win_watchdog_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [23:0] wdata = '0, rdata;
  logic        irq, rst_req;

  int checks = 0, fails = 0, cyc = 0, rst_seen = 0;
  int    exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  win_watchdog uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .rst_req_o(rst_req)
  );

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every reset request must match a predicted cycle
  always @(negedge clk) begin
    if (rst_n && rst_req) begin
      rst_seen++;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R5 unexpected reset request actual=%0d expected=none", cyc);
      end else begin
        automatic int    e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (cyc != e) begin
          fails++;
          $display("FAIL %s reset cycle actual=%0d expected=%0d", t, cyc, e);
        end
      end
    end
  end

  task automatic expect_rst(input int lat, input string tag);
    exp_q.push_back(cyc + 1 + lat);
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [23:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [23:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic feed(input int lat, input string tag);
    wr(3'd2, 24'hAA);
    if (lat >= 0) expect_rst(lat, tag);
    wr(3'd2, 24'h55);
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic wait_rst(input int k);
    while (rst_seen < k) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R5 watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [23:0] v;
    int s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); chk("R1 ctrl", v, 24'h0);
    rd(3'd1, v); chk("R1 tc", v, 24'hFFFFFF);
    rd(3'd3, v); chk("R1 cnt", v, 24'hFFFFFF);
    rd(3'd4, v); chk("R1 warn", v, 24'h0);
    rd(3'd5, v); chk("R1 win", v, 24'hFFFFFF);
    chk("R1 irq", {23'h0, irq}, 24'h0);
    chk("R1 rst_req", {23'h0, rst_req}, 24'h0);

    // R2 floor
    wr(3'd1, 24'd5);    rd(3'd1, v); chk("R2 clamp", v, 24'd256);
    wr(3'd1, 24'd1000); rd(3'd1, v); chk("R2 pass", v, 24'd1000);

    // R4 / R8 disabled: no effect
    feed(-1, "R4");
    rd(3'd3, v); chk("R4 disabled feed", v, 24'hFFFFFF);
    wr(3'd2, 24'h12);
    rd(3'd0, v); chk("R8 disabled bad key", v, 24'h0);

    // Phase B: R3, R4, R9, R5, R11
    wr(3'd1, 24'd300); wr(3'd4, 24'd250);
    wr(3'd0, 24'h1); wr(3'd0, 24'h0);
    rd(3'd0, v); chk("R3 enable lock", v, 24'h01);
    feed(1200, "R5");
    s = cyc;
    wait_to(s + 40);
    rd(3'd3, v); chk("R4 count", v, 24'd290);
    wait_to(s + 200);
    chk("R9 before", {23'h0, irq}, 24'h0);
    @(negedge clk);
    chk("R9 set", {23'h0, irq}, 24'h1);
    wait_to(s + 220);
    chk("R9 sticky", {23'h0, irq}, 24'h1);
    wr(3'd0, 24'h8);
    chk("R9 clear", {23'h0, irq}, 24'h0);
    rd(3'd0, v); chk("R4 running", v, 24'h11);
    wait_rst(1);
    rd(3'd0, v); chk("R11 ctrl", v, 24'h04);
    rd(3'd1, v); chk("R11 tc", v, 24'hFFFFFF);
    wr(3'd0, 24'h4);
    rd(3'd0, v); chk("R11 flag clear", v, 24'h0);

    // Phase C: R6, R7
    wr(3'd1, 24'd300); wr(3'd5, 24'd260); wr(3'd0, 24'h1);
    feed(-1, "R7");
    s = cyc;
    wait_to(s + 200);
    feed(-1, "R7");
    rd(3'd3, v); chk("R6 reload", v, 24'd300);
    feed(0, "R7");
    wait_rst(2);
    rd(3'd0, v); chk("R7 window reset", v, 24'h04);
    wr(3'd0, 24'h4);

    // Phase D: R3 protect lock, R10, R8 interleaved access
    wr(3'd1, 24'd300); wr(3'd4, 24'd250);
    wr(3'd0, 24'h3); wr(3'd0, 24'h1);
    rd(3'd0, v); chk("R3 protect lock", v, 24'h03);
    wr(3'd1, 24'd400);
    rd(3'd1, v); chk("R10 blocked idle", v, 24'd300);
    feed(-1, "R10");
    s = cyc;
    wait_to(s + 100);
    wr(3'd1, 24'd400);
    rd(3'd1, v); chk("R10 blocked above", v, 24'd300);
    wait_to(s + 200);
    wr(3'd1, 24'd400);
    rd(3'd1, v); chk("R10 accepted at warn", v, 24'd400);
    wr(3'd2, 24'hAA);
    expect_rst(0, "R8");
    rd(3'd0, v);
    wait_rst(3);
    rd(3'd0, v); chk("R8 interleave reset", v, 24'h04);
    wr(3'd0, 24'h4);

    // Phase E: R8 wrong first key while enabled
    wr(3'd0, 24'h1);
    expect_rst(0, "R8");
    wr(3'd2, 24'h12);
    wait_rst(4);
    rd(3'd0, v); chk("R8 wrong key reset", v, 24'h04);

    repeat (20) @(negedge clk);
    chk("R5 pending predictions", 24'(exp_q.size()), 24'h0);
    summary();
    $finish;
  end
endmodule